// File: doc/BRIEF.md
# Compute Dispatch Thread-ID Walker

This block walks a three-dimensional compute dispatch and produces one output beat per thread. A start pulse captures the group-grid dimensions and the per-group thread dimensions. The block then sends every thread of every group out on a valid/ready stream, and pulses done once the final beat has been taken.

Each beat carries four related identifier spaces for its thread:
- the group coordinate;
- the thread coordinate inside the group;
- the global dispatch coordinate, which is group times group size plus local, per axis;
- the flat in-group index.

Each beat also carries its wavefront packing: the wavefront number, the lane number and a lane-valid mask for that wavefront. A wavefront has a fixed number of lanes, 64 by default.

A dispatch unit or a lane-packing front end connects downstream of the stream. Packed ports index axis x as element 0, y as element 1 and z as element 2.

Top module: `tid_walker`

## Requirements
- R1: After reset, valid_o, done_o and busy_o are all 0.
- R2: For a grid of GX*GY*GZ groups, each holding BX*BY*BZ threads, exactly GX*GY*GZ*BX*BY*BZ beats are emitted. Groups go in order with x changing fastest, then y, then z. Inside each group, threads go with local x fastest, then y, then z. Every coordinate stays below its dimension.
- R3: On each axis, gid_o equals grp_id_o times the group size on that axis plus loc_id_o. For example, group (2,1,0) with size (8,2,4) and local (5,1,0) gives (21,3,0).
- R4: flat_o equals z*BX*BY + y*BX + x for the local coordinate (x,y,z). For example, local (5,1,0) with BX=8 and BY=2 gives 13.
- R5: lane_o equals flat_o mod LANES, and wave_o equals flat_o / LANES. With LANES=64, a group of exactly 64 threads lies entirely in wavefront 0.
- R6: Bit i of lane_mask_o is 1 exactly when wave_o*LANES + i is less than BX*BY*BZ. Every wavefront except the last of a group is therefore full, and the last one is partial when the group size is not a multiple of LANES.
- R7: While valid_o is 1 and ready_i is 0, valid_o stays 1 and every output field holds its value.
- R8: done_o is 1 for exactly one cycle. That cycle is the one after the edge that accepts the final beat, and valid_o is 0 during it.
- R9: A start pulse that arrives while busy_o is 1 has no effect, and the running sequence continues unchanged.
- R10: If any of the six dimensions is 0 at start, no beat is emitted and done_o is 1 in the cycle after the start edge.
- R11: Dimensions are captured only at an accepted start. Changing the dimension inputs during a run does not alter the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| grid_dim_i | input | 3 x GRID_W | Group counts per axis (x,y,z) |
| blk_dim_i | input | 3 x BLK_W | Threads per group per axis (x,y,z) |
| ready_i | input | 1 | Downstream accepts the beat |
| valid_o | output | 1 | Beat present |
| grp_id_o | output | 3 x GRID_W | Group coordinate |
| loc_id_o | output | 3 x BLK_W | Thread coordinate within group |
| gid_o | output | 3 x (GRID_W+BLK_W) | Global dispatch coordinate |
| flat_o | output | 3*BLK_W | Flat in-group index |
| wave_o | output | 3*BLK_W-log2(LANES) | Wavefront number within group |
| lane_o | output | log2(LANES) | Lane within wavefront |
| lane_mask_o | output | LANES | Populated lanes of this wavefront |
| busy_o | output | 1 | Dispatch in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: GRID_W=3, BLK_W=4 and LANES=64. With these values a single group can reach 15x15x15 = 3375 threads. That spans 53 wavefronts, and the last one holds a 47-lane partial mask. A 5x4x4 group yields 80 threads, which gives a 16-lane partial second wavefront. An 8x2x4 group fills exactly one wavefront, and a 4x3x2 grid of such groups exercises every group-axis carry. Dispatches of one thread and dispatches with a zero dimension cover the edge cases of the dimension fields.

// File: rtl/tid_pkg.sv
package tid_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } tid_state_e;
endpackage

// File: rtl/tid_axis_ctr.sv
module tid_axis_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] val_o,
  output logic         last_o
);
  logic [W-1:0] val_q;

  assign last_o = (val_q == lim_i - W'(1));
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= '0;
    else if (clr_i)    val_q <= '0;
    else if (inc_i)    val_q <= last_o ? '0 : val_q + W'(1);
  end
endmodule

// File: rtl/tid_gid_calc.sv
module tid_gid_calc #(
  parameter int GRID_W = 3,
  parameter int BLK_W  = 4,
  localparam int GID_W = GRID_W + BLK_W
) (
  input  logic [2:0][GRID_W-1:0] grp_i,
  input  logic [2:0][BLK_W-1:0]  size_i,
  input  logic [2:0][BLK_W-1:0]  loc_i,
  output logic [2:0][GID_W-1:0]  gid_o
);
  for (genvar a = 0; a < 3; a++) begin : g_axis
    assign gid_o[a] = GID_W'(grp_i[a]) * GID_W'(size_i[a]) + GID_W'(loc_i[a]);
  end
endmodule

// File: rtl/tid_wave_pack.sv
module tid_wave_pack #(
  parameter int FLAT_W = 12,
  parameter int LANES  = 64,
  localparam int LANE_W = $clog2(LANES),
  localparam int WAVE_W = FLAT_W - LANE_W
) (
  input  logic [FLAT_W-1:0] flat_i,
  input  logic [FLAT_W-1:0] total_i,
  output logic [WAVE_W-1:0] wave_o,
  output logic [LANE_W-1:0] lane_o,
  output logic [LANES-1:0]  mask_o
);
  logic [FLAT_W-1:0] base, left;

  assign wave_o = flat_i[FLAT_W-1:LANE_W];
  assign lane_o = flat_i[LANE_W-1:0];
  assign base   = {wave_o, {LANE_W{1'b0}}};
  assign left   = total_i - base;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask_o[i] = (32'(left) > 32'(i));
  end
endmodule

// File: rtl/tid_walker.sv
module tid_walker
  import tid_pkg::*;
#(
  parameter int GRID_W = 3,
  parameter int BLK_W  = 4,
  parameter int LANES  = 64,
  localparam int FLAT_W = 3 * BLK_W,
  localparam int GID_W  = GRID_W + BLK_W,
  localparam int LANE_W = $clog2(LANES),
  localparam int WAVE_W = FLAT_W - LANE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [2:0][GRID_W-1:0]  grid_dim_i,
  input  logic [2:0][BLK_W-1:0]   blk_dim_i,
  input  logic                    ready_i,
  output logic                    valid_o,
  output logic [2:0][GRID_W-1:0]  grp_id_o,
  output logic [2:0][BLK_W-1:0]   loc_id_o,
  output logic [2:0][GID_W-1:0]   gid_o,
  output logic [FLAT_W-1:0]       flat_o,
  output logic [WAVE_W-1:0]       wave_o,
  output logic [LANE_W-1:0]       lane_o,
  output logic [LANES-1:0]        lane_mask_o,
  output logic                    busy_o,
  output logic                    done_o
);
  tid_state_e state_q, state_d;
  logic [2:0][GRID_W-1:0] grid_q;
  logic [2:0][BLK_W-1:0]  blk_q;
  logic [FLAT_W-1:0]      total_q, flat_q;

  logic start_ok, any_zero, accept, grp_wrap, last_beat;
  logic [6:0] carry;
  logic [5:0] last;

  assign start_ok = start_i && (state_q == ST_IDLE);
  assign any_zero = (grid_dim_i[0] == '0) || (grid_dim_i[1] == '0) || (grid_dim_i[2] == '0) ||
                    (blk_dim_i[0] == '0)  || (blk_dim_i[1] == '0)  || (blk_dim_i[2] == '0);
  assign valid_o  = (state_q == ST_RUN);
  assign accept   = valid_o && ready_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FIN);

  // carry chain: local x,y,z then group x,y,z
  assign carry[0] = accept;
  for (genvar a = 0; a < 3; a++) begin : g_loc
    tid_axis_ctr #(.W(BLK_W)) u_ctr (
      .clk_i, .rst_ni, .clr_i(start_ok), .inc_i(carry[a]),
      .lim_i(blk_q[a]), .val_o(loc_id_o[a]), .last_o(last[a])
    );
    assign carry[a+1] = carry[a] && last[a];
  end
  for (genvar a = 0; a < 3; a++) begin : g_grp
    tid_axis_ctr #(.W(GRID_W)) u_ctr (
      .clk_i, .rst_ni, .clr_i(start_ok), .inc_i(carry[3+a]),
      .lim_i(grid_q[a]), .val_o(grp_id_o[a]), .last_o(last[3+a])
    );
    assign carry[4+a] = carry[3+a] && last[3+a];
  end

  assign grp_wrap  = &last[2:0];
  assign last_beat = &last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_ok) state_d = any_zero ? ST_FIN : ST_RUN;
      ST_RUN:  if (accept && last_beat) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      grid_q  <= '0;
      blk_q   <= '0;
      total_q <= '0;
      flat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        grid_q  <= grid_dim_i;
        blk_q   <= blk_dim_i;
        total_q <= FLAT_W'(blk_dim_i[0]) * FLAT_W'(blk_dim_i[1]) * FLAT_W'(blk_dim_i[2]);
        flat_q  <= '0;
      end else if (accept) begin
        flat_q  <= grp_wrap ? '0 : flat_q + FLAT_W'(1);
      end
    end
  end

  assign flat_o = flat_q;

  tid_gid_calc #(.GRID_W(GRID_W), .BLK_W(BLK_W)) u_gid (
    .grp_i(grp_id_o), .size_i(blk_q), .loc_i(loc_id_o), .gid_o(gid_o)
  );

  tid_wave_pack #(.FLAT_W(FLAT_W), .LANES(LANES)) u_wave (
    .flat_i(flat_q), .total_i(total_q), .wave_o(wave_o), .lane_o(lane_o), .mask_o(lane_mask_o)
  );
endmodule

// File: rtl/tid_walker_chk.sv
module tid_walker_chk #(
  parameter int GRID_W = 3,
  parameter int BLK_W  = 4,
  parameter int LANES  = 64,
  localparam int FLAT_W = 3 * BLK_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   ready_i,
  input logic                   valid_o,
  input logic                   done_o,
  input logic [2:0][GRID_W-1:0] grp_id_o,
  input logic [2:0][BLK_W-1:0]  loc_id_o,
  input logic [FLAT_W-1:0]      flat_o,
  input logic [LANE_W-1:0]      lane_o,
  input logic [LANES-1:0]       lane_mask_o,
  input logic [2:0][GRID_W-1:0] grid_q_i,
  input logic [2:0][BLK_W-1:0]  blk_q_i,
  input logic                   last_beat_i
);
  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(flat_o) && $stable(grp_id_o) && $stable(loc_id_o)
                            && $stable(lane_mask_o));

  // R4
  flat_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> 32'(flat_o) == 32'(loc_id_o[2]) * 32'(blk_q_i[0]) * 32'(blk_q_i[1])
                              + 32'(loc_id_o[1]) * 32'(blk_q_i[0]) + 32'(loc_id_o[0]));

  // R2
  coord_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> loc_id_o[0] < blk_q_i[0] && loc_id_o[1] < blk_q_i[1] && loc_id_o[2] < blk_q_i[2]
             && grp_id_o[0] < grid_q_i[0] && grp_id_o[1] < grid_q_i[1] && grp_id_o[2] < grid_q_i[2]);

  // R6
  own_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> lane_mask_o[lane_o] && lane_mask_o[0]);

  // R8
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_beat_i |=> done_o && !valid_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind tid_walker tid_walker_chk #(.GRID_W(GRID_W), .BLK_W(BLK_W), .LANES(LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready_i), .valid_o(valid_o), .done_o(done_o),
  .grp_id_o(grp_id_o), .loc_id_o(loc_id_o), .flat_o(flat_o), .lane_o(lane_o),
  .lane_mask_o(lane_mask_o), .grid_q_i(grid_q), .blk_q_i(blk_q), .last_beat_i(last_beat)
);

// File: tb/tid_walker_tb.sv
module tid_walker_tb;
  localparam int GRID_W = 3;
  localparam int BLK_W  = 4;
  localparam int LANES  = 64;
  localparam int FLAT_W = 3 * BLK_W;
  localparam int GID_W  = GRID_W + BLK_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int WAVE_W = FLAT_W - LANE_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic ready_i = 1'b0;
  logic [2:0][GRID_W-1:0] grid_dim_i = '0;
  logic [2:0][BLK_W-1:0]  blk_dim_i = '0;
  logic valid_o, busy_o, done_o;
  logic [2:0][GRID_W-1:0] grp_id_o;
  logic [2:0][BLK_W-1:0]  loc_id_o;
  logic [2:0][GID_W-1:0]  gid_o;
  logic [FLAT_W-1:0]      flat_o;
  logic [WAVE_W-1:0]      wave_o;
  logic [LANE_W-1:0]      lane_o;
  logic [LANES-1:0]       lane_mask_o;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;

  tid_walker #(.GRID_W(GRID_W), .BLK_W(BLK_W), .LANES(LANES)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reset_test();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 valid", 64'(valid_o), 0);
    chk("R1 done", 64'(done_o), 0);
    chk("R1 busy", 64'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic set_dims(input int gx, gy, gz, bx, by, bz);
    grid_dim_i[0] = GRID_W'(gx); grid_dim_i[1] = GRID_W'(gy); grid_dim_i[2] = GRID_W'(gz);
    blk_dim_i[0]  = BLK_W'(bx);  blk_dim_i[1]  = BLK_W'(by);  blk_dim_i[2]  = BLK_W'(bz);
  endtask

  // full dispatch with optional stalls and a mid-run start (inj = beat index, -1 none)
  task automatic run_disp(input int gx, gy, gz, bx, by, bz, input bit stall, input int inj);
    int tot = bx * by * bz;
    int n = 0;
    set_dims(gx, gy, gz, bx, by, bz);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int gzi = 0; gzi < gz; gzi++)
    for (int gyi = 0; gyi < gy; gyi++)
    for (int gxi = 0; gxi < gx; gxi++)
    for (int lz = 0; lz < bz; lz++)
    for (int ly = 0; ly < by; ly++)
    for (int lx = 0; lx < bx; lx++) begin
      int f = lz * bx * by + ly * bx + lx;
      int w = f / LANES;
      int left = tot - w * LANES;
      logic [63:0] emask = (left >= 64) ? '1 : ((64'd1 << left) - 64'd1);
      logic [2:0][GRID_W-1:0] eg;
      logic [2:0][BLK_W-1:0]  el;
      logic [2:0][GID_W-1:0]  egid;
      int spins = 0;
      bit held = 1'b0;
      logic [FLAT_W-1:0] s_flat;
      logic [2:0][GRID_W-1:0] s_grp;
      logic [LANES-1:0] s_mask;
      eg[0] = GRID_W'(gxi); eg[1] = GRID_W'(gyi); eg[2] = GRID_W'(gzi);
      el[0] = BLK_W'(lx);   el[1] = BLK_W'(ly);   el[2] = BLK_W'(lz);
      egid[0] = GID_W'(gxi * bx + lx);
      egid[1] = GID_W'(gyi * by + ly);
      egid[2] = GID_W'(gzi * bz + lz);
      forever begin
        @(negedge clk_i);
        if (held) begin
          chk("R7 hold valid", 64'(valid_o), 1);
          chk("R7 hold flat", 64'(flat_o), 64'(s_flat));
          chk("R7 hold grp", 64'(grp_id_o), 64'(s_grp));
          chk("R7 hold mask", 64'(lane_mask_o), 64'(s_mask));
          held = 1'b0;
        end
        if (n == inj && spins == 0) begin
          start_i = 1'b1;  // R9 / R11: ignored start, altered dims
          set_dims(1, 1, 1, 2, 2, 2);
        end else begin
          start_i = 1'b0;
        end
        ready_i = !stall || (spins % 2 == 1);
        if (valid_o && ready_i) break;
        if (valid_o) begin
          held = 1'b1; s_flat = flat_o; s_grp = grp_id_o; s_mask = lane_mask_o;
        end
        spins++;
        if (spins > 50) begin
          chk("R2 beat timeout", 64'(valid_o), 1);
          ready_i = 1'b0;
          return;
        end
      end
      chk("R2 grp order", 64'(grp_id_o), 64'(eg));
      chk("R2 loc order", 64'(loc_id_o), 64'(el));
      chk("R3 global id", 64'(gid_o), 64'(egid));
      chk("R4 flat", 64'(flat_o), 64'(f));
      chk("R5 wave", 64'(wave_o), 64'(w));
      chk("R5 lane", 64'(lane_o), 64'(f % LANES));
      chk("R6 mask", 64'(lane_mask_o), emask);
      n++;
    end
    @(negedge clk_i);
    start_i = 1'b0;
    ready_i = 1'b0;
    chk("R8 done after last", 64'(done_o), 1);
    chk("R2 no extra beat", 64'(valid_o), 0);
    @(negedge clk_i);
    chk("R8 done one cycle", 64'(done_o), 0);
    chk("R8 idle after done", 64'(busy_o), 0);
  endtask

  task automatic zero_dim_test();
    set_dims(2, 0, 1, 3, 3, 3);
    ready_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10 no beat", 64'(valid_o), 0);
    chk("R10 done", 64'(done_o), 1);
    @(negedge clk_i);
    chk("R10 done ends", 64'(done_o), 0);
    chk("R10 no beat later", 64'(valid_o), 0);
    set_dims(1, 1, 1, 4, 0, 1);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10 zero block done", 64'(done_o), 1);
    chk("R10 zero block no beat", 64'(valid_o), 0);
    ready_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    reset_test();
    run_disp(4, 3, 2, 8, 2, 4, 1'b0, -1);   // R2 R3 R5 full 64-lane groups
    run_disp(2, 1, 1, 5, 4, 4, 1'b1, -1);   // R6 partial second wave, R7 stalls
    run_disp(1, 2, 3, 3, 1, 2, 1'b1, 7);    // R9 R11 ignored start mid-run
    run_disp(1, 1, 1, 1, 1, 1, 1'b0, -1);   // single thread
    zero_dim_test();                         // R10
    run_disp(1, 1, 1, 15, 15, 15, 1'b0, -1); // R6 47-lane last wave
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule